// File: doc/BRIEF.md
# Byte-Masked Remote Mailbox Writer

This block turns a 64-bit send command into a 32-bit store into the register space of another core. The payload word is taken from the upper half of the command. A four-bit keep mask chooses which destination bytes keep their current contents. When any keep bit is set, the block first reads the destination word, merges the new bytes into it, and writes the result back. When no keep bit is set, it skips the read and writes the whole word at once.

Two command flavours exist. A mail command targets one of eight mailbox words at a fixed offset above a mailbox base. An any command carries its own 16-bit destination address. The target core is named by a 10-bit field of the command. An index at or beyond the number of cores raises a decode error pulse, and no bus access is made.

Downstream, the block is the master of a simple register port. A request is held with its core index, address, direction and write data until the slave acknowledges it. Upstream, a ready signal pushes back new commands while a job is in flight.

Top module: `mbox_writer`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bus_req`, `done_o` and `dec_err_o` are 0.
- R2: A command presented with `cmd_wide` = 0 is ignored: no bus access, no `done_o` and no `dec_err_o` follow.
- R3: The target core index is command bits 25:16. Both the read and the write of a job drive that index on `bus_core`.
- R4: Command bits 30:27 are the keep mask, where bit i covers byte i (bits 8i+7:8i). A keep bit of 1 leaves that destination byte at its old value. A keep bit of 0 replaces it with the matching byte of command bits 63:32. Command bits 31 and 26 have no effect.
- R5: When the keep mask is 0, no read is issued and exactly one write of command bits 63:32 is made. When the mask is nonzero, exactly one read precedes exactly one write to the same address.
- R6: For a mail command (`cmd_any` = 0), the address is MBOX_BASE + 0x20 + (command bits 4:2 times 4).
- R7: For an any command (`cmd_any` = 1), the address is command bits 15:0 with bits 1:0 forced to 0.
- R8: A core index of NUM_CORES or above gives a one-cycle `dec_err_o` pulse in the cycle after acceptance. It makes no bus access, and `cmd_ready` stays 1.
- R9: `cmd_ready` is 0 from the cycle after a valid command is accepted until the job ends. A command presented meanwhile is not taken.
- R10: `done_o` pulses for one cycle directly after the write is acknowledged. `cmd_ready` returns to 1 in the next cycle.
- R11: Once raised, `bus_req` stays high, with `bus_we`, `bus_core`, `bus_addr` and `bus_wdata` unchanged, until `bus_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; command taken when valid and ready |
| cmd_wide | input | 1 | 1 when the access is a full 64-bit store |
| cmd_any | input | 1 | 0 selects a mail command, 1 selects an any command |
| cmd_word | input | 64 | Command word |
| done_o | output | 1 | Job finished pulse |
| dec_err_o | output | 1 | Unknown target core pulse |
| bus_req | output | 1 | Register port request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_core | output | IDX_W (2) | Target core index |
| bus_addr | output | ADDR_W (16) | Word-aligned register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
The bench targets several keep-mask patterns that an inverted strobe sense would get wrong. That error would replace the bytes that should survive, and the merged word in the slave memory would not match the expected value. Zero and all-ones masks show whether the read is skipped or kept when it should be: a spurious read, or a missing read, breaks the expected access order. It also aims unknown core indices (the first index past the end and the largest possible index) at the block, where a leak would appear as a stray access or a missing error pulse. Junk commands held on the input during each busy window would surface as an extra, unexpected access if back-pressure were missing. Slave latencies from zero to three cycles show whether requests stay stable until acknowledged.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
    localparam int WORD_W   = 32;
    localparam int NBYTES   = WORD_W / 8;
    localparam int CMD_W    = 64;
    localparam int ID_LSB   = 16;
    localparam int ID_W     = 10;
    localparam int KEEP_LSB = 27;
    localparam int DATA_LSB = 32;
    localparam int SLOT_OFS = 32'h20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } mbw_state_e;
endpackage

// File: rtl/mbw_decode.sv
module mbw_decode
    import mbw_pkg::*;
#(
    parameter int          NUM_CORES = 4,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] MBOX_BASE = 16'h1000,
    localparam int         IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              cmd_any,
    output logic              core_ok,
    output logic [IDX_W-1:0]  core_idx,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    output logic [NBYTES-1:0] keep
);
    logic [ID_W-1:0] id_field;
    logic [15:0]     mail_addr;
    logic [15:0]     any_addr;

    always_comb begin
        id_field  = cmd_word[ID_LSB +: ID_W];
        core_ok   = (32'(id_field) < 32'(NUM_CORES));
        core_idx  = id_field[IDX_W-1:0];
        keep      = cmd_word[KEEP_LSB +: NBYTES];
        wdata     = cmd_word[DATA_LSB +: WORD_W];
        mail_addr = MBOX_BASE + 16'(SLOT_OFS) + {11'd0, cmd_word[4:2], 2'b00};
        any_addr  = {cmd_word[15:2], 2'b00};
        addr      = cmd_any ? ADDR_W'(any_addr) : ADDR_W'(mail_addr);
    end
endmodule

// File: rtl/mbw_merge.sv
module mbw_merge
    import mbw_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    input  logic [NBYTES-1:0] keep,
    output logic [WORD_W-1:0] merged
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign merged[8*b +: 8] = keep[b] ? old_word[8*b +: 8] : new_word[8*b +: 8];
    end
endmodule

// File: rtl/mbw_seq.sv
module mbw_seq
    import mbw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              reject,
    input  logic [IDX_W-1:0]  job_core,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [WORD_W-1:0] job_data,
    input  logic [NBYTES-1:0] job_keep,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] merged,
    output logic              idle,
    output logic              done,
    output logic              err,
    output logic              bus_req,
    output logic              bus_we,
    output logic [IDX_W-1:0]  bus_core,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [NBYTES-1:0] keep_held
);
    typedef struct packed {
        mbw_state_e        st;
        logic [IDX_W-1:0]  core;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [NBYTES-1:0] keep;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (reject) begin
                    s_d.err = 1'b1;
                end else if (start) begin
                    s_d.core = job_core;
                    s_d.addr = job_addr;
                    s_d.data = job_data;
                    s_d.keep = job_keep;
                    s_d.st   = (job_keep != '0) ? ST_READ : ST_WRITE;
                end
            end
            ST_READ: begin
                if (bus_ack) begin
                    s_d.data = merged;
                    s_d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (bus_ack) begin
                    s_d.done = 1'b1;
                    s_d.st   = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle      = (s_q.st == ST_IDLE);
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign bus_req   = (s_q.st == ST_READ) || (s_q.st == ST_WRITE);
    assign bus_we    = (s_q.st == ST_WRITE);
    assign bus_core  = s_q.core;
    assign bus_addr  = s_q.addr;
    assign bus_wdata = s_q.data;
    assign keep_held = s_q.keep;

    // R5
    read_needs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (keep_held != '0));

    // R5
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we && $stable(bus_addr) && $stable(bus_core)));

    // R10
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_req && bus_we && bus_ack));
endmodule

// File: rtl/mbox_writer.sv
module mbox_writer
    import mbw_pkg::*;
#(
    parameter int          NUM_CORES = 4,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] MBOX_BASE = 16'h1000,
    localparam int         IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_wide,
    input  logic              cmd_any,
    input  logic [63:0]       cmd_word,
    output logic              done_o,
    output logic              dec_err_o,
    output logic              bus_req,
    output logic              bus_we,
    output logic [IDX_W-1:0]  bus_core,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    logic              core_ok;
    logic [IDX_W-1:0]  dec_core;
    logic [ADDR_W-1:0] dec_addr;
    logic [WORD_W-1:0] dec_data;
    logic [NBYTES-1:0] dec_keep;
    logic [NBYTES-1:0] keep_held;
    logic [WORD_W-1:0] merged;
    logic              accept;
    logic              idle;

    mbw_decode #(
        .NUM_CORES(NUM_CORES),
        .ADDR_W   (ADDR_W),
        .MBOX_BASE(MBOX_BASE)
    ) u_decode (
        .cmd_word(cmd_word),
        .cmd_any (cmd_any),
        .core_ok (core_ok),
        .core_idx(dec_core),
        .addr    (dec_addr),
        .wdata   (dec_data),
        .keep    (dec_keep)
    );

    mbw_merge u_merge (
        .old_word(bus_rdata),
        .new_word(bus_wdata),
        .keep    (keep_held),
        .merged  (merged)
    );

    assign accept = cmd_valid && idle && cmd_wide;

    mbw_seq #(
        .ADDR_W(ADDR_W),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && core_ok),
        .reject   (accept && !core_ok),
        .job_core (dec_core),
        .job_addr (dec_addr),
        .job_data (dec_data),
        .job_keep (dec_keep),
        .bus_ack  (bus_ack),
        .merged   (merged),
        .idle     (idle),
        .done     (done_o),
        .err      (dec_err_o),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_core (bus_core),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .keep_held(keep_held)
    );

    assign cmd_ready = idle;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_core) && $stable(bus_wdata)));

    // R9
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cmd_ready);

    // R8
    err_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err_o |-> (cmd_ready && !bus_req && !done_o));

    // R10
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (cmd_ready && !done_o));

    // R2
    narrow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !cmd_wide) |=> (cmd_ready && !dec_err_o && !bus_req));
endmodule

// File: tb/tb_mbox_writer.sv
module tb_mbox_writer;
    localparam int          NCORE = 4;
    localparam logic [15:0] MBOX  = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_wide = 1'b0;
    logic        cmd_any = 1'b0;
    logic [63:0] cmd_word = '0;
    logic        cmd_ready, done_o, dec_err_o;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [1:0]  bus_core;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int cnt = 0;
    int cycles = 0;

    logic [31:0] mem [int];
    logic        q_we   [$];
    logic [1:0]  q_core [$];
    logic [15:0] q_addr [$];
    logic [31:0] q_data [$];

    always #2.5 clk = ~clk;

    mbox_writer #(.NUM_CORES(NCORE), .MBOX_BASE(MBOX)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_wide(cmd_wide), .cmd_any(cmd_any), .cmd_word(cmd_word),
        .done_o(done_o), .dec_err_o(dec_err_o), .bus_req(bus_req), .bus_we(bus_we),
        .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [31:0] peek(input int key);
        if (mem.exists(key)) return mem[key];
        return 32'(key) * 32'h9E37_79B1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slave model: acknowledges after lat cycles and compares against the expected access list
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            bus_ack = 1'b0;
            cnt = 0;
        end else if (bus_ack) begin
            bus_ack = 1'b0;
            cnt = 0;
        end else if (bus_req) begin
            if (cnt >= lat) begin
                bus_ack = 1'b1;
                if (q_we.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9 R2 R8 unexpected access actual=we%0d core%0d addr %h expected=none",
                             bus_we, bus_core, bus_addr);
                end else begin
                    check("R5 access kind", 32'(bus_we), 32'(q_we[0]));
                    check("R3 access core", 32'(bus_core), 32'(q_core[0]));
                    check("R6 R7 access address", 32'(bus_addr), 32'(q_addr[0]));
                    if (q_we[0]) check("R4 write data", bus_wdata, q_data[0]);
                    void'(q_we.pop_front());
                    void'(q_core.pop_front());
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                end
                if (bus_we) mem[int'(bus_core) * 65536 + int'(bus_addr)] = bus_wdata;
                else bus_rdata = peek(int'(bus_core) * 65536 + int'(bus_addr));
            end else begin
                cnt++;
            end
        end
    end

    function automatic logic [63:0] mk(input int core, input logic [3:0] keep,
                                       input logic [31:0] data, input logic [15:0] low);
        logic [63:0] w = '0;
        w[63:32] = data;
        w[30:27] = keep;
        w[25:16] = 10'(core);
        w[15:0]  = low;
        return w;
    endfunction

    task automatic issue(input string tag, input bit any, input bit wide, input logic [63:0] w);
        int          core = int'(w[25:16]);
        logic [3:0]  keep = w[30:27];
        logic [31:0] nd = w[63:32];
        logic [15:0] addr;
        logic [31:0] old, exp;
        bit          bad = (core >= NCORE);
        int          key;
        int          nd_seen = 0;
        int          ne_seen = 0;
        addr = any ? (w[15:0] & 16'hFFFC) : (MBOX + 16'h20 + (w[15:0] & 16'h001C));
        key = core * 65536 + int'(addr);
        old = peek(key);
        for (int i = 0; i < 4; i++) exp[8*i +: 8] = keep[i] ? old[8*i +: 8] : nd[8*i +: 8];
        if (wide && !bad) begin
            if (keep != 4'd0) begin
                q_we.push_back(1'b0); q_core.push_back(2'(core));
                q_addr.push_back(addr); q_data.push_back(32'd0);
            end
            q_we.push_back(1'b1); q_core.push_back(2'(core));
            q_addr.push_back(addr); q_data.push_back(exp);
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_any = any; cmd_wide = wide; cmd_word = w;
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < 40; c++) begin
            if (done_o) nd_seen++;
            if (dec_err_o) ne_seen++;
            if (!cmd_ready) begin
                // R9: junk held on the input while busy must not be taken
                cmd_valid = 1'b1; cmd_any = 1'b1; cmd_wide = 1'b1;
                cmd_word = mk(0, 4'd0, 32'hDEAD_BEEF, 16'h0040);
            end else begin
                cmd_valid = 1'b0;
            end
            if (c > 4 && cmd_ready && q_we.size() == 0) break;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        if (!wide) begin
            check({tag, " R2 no done"}, 32'(nd_seen), 0);
            check({tag, " R2 no error"}, 32'(ne_seen), 0);
        end else if (bad) begin
            check({tag, " R8 error pulse count"}, 32'(ne_seen), 1);
            check({tag, " R8 no done"}, 32'(nd_seen), 0);
        end else begin
            check({tag, " R10 done pulse count"}, 32'(nd_seen), 1);
            check({tag, " R8 no error"}, 32'(ne_seen), 0);
            check({tag, " R4 stored word"}, peek(key), exp);
        end
        check({tag, " R5 pending accesses"}, 32'(q_we.size()), 0);
        check({tag, " R9 R10 ready after job"}, 32'(cmd_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", 32'(cmd_ready), 1);
        check("R1 req", 32'(bus_req), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 err", 32'(dec_err_o), 0);

        lat = 0;
        issue("mail zero mask", 1'b0, 1'b1, mk(1, 4'b0000, 32'hA1B2_C3D4, 16'h0014));
        issue("mail keep 0101", 1'b0, 1'b1, mk(2, 4'b0101, 32'h1122_3344, 16'h001C));
        lat = 1;
        issue("any keep all", 1'b1, 1'b1, mk(3, 4'b1111, 32'h5555_AAAA, 16'h1236));
        lat = 3;
        issue("any zero mask far", 1'b1, 1'b1, mk(0, 4'b0000, 32'hCAFE_F00D, 16'hFFFF));
        issue("narrow ignored", 1'b1, 1'b0, mk(1, 4'b0011, 32'h0BAD_0BAD, 16'h0100));
        issue("core past end", 1'b0, 1'b1, mk(4, 4'b0000, 32'h0123_4567, 16'h0000));
        issue("core max", 1'b1, 1'b1, mk(1023, 4'b1001, 32'h89AB_CDEF, 16'h0200));
        lat = 2;
        issue("mail keep 1000 bits 31 26", 1'b0, 1'b1,
              mk(1, 4'b1000, 32'h7777_8888, 16'h0014) | 64'h0000_0000_8400_0000);
        issue("any keep 0110 reuse", 1'b1, 1'b1, mk(0, 4'b0110, 32'h0F0E_0D0C, 16'hFFFC));
        lat = 0;
        issue("mail keep 0011 slot0", 1'b0, 1'b1, mk(3, 4'b0011, 32'hFEDC_BA98, 16'hFFE3));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule